// File: doc/BRIEF.md
# Time-Multiplexed PN Code Matched Filter

This block correlates a stream of signed samples, one sample per chip, against a 255-chip pseudo-noise code. It produces one full-length correlation result for every accepted sample. A full-length parallel correlator would need 255 taps. Here a tap bank of only 1/N of the code length is used instead, and it is reused over N consecutive core-clock phases. Each phase multiplies the short sample window by one segment of the code. The partial sums of the earlier segments are held back in delay lines until the last segment's partial sum for the same window is ready, and then all of them are added together.

The code is supplied as a quasi-static bit vector. The result is compared with a programmable magnitude threshold to raise an acquisition flag. The segment count N is a parameter and may be 2 or 4. The core clock must run at least N times faster than the sample strobe.

Top module: `pn_tdm_correlator`

## Requirements
- R1: Code bit m (index 0 to 254) stands for +1 when it is 0 and for -1 when it is 1. Let x(n) be the sample accepted with the n-th strobe. After sample n the result `corr_o` equals the sum over m from 0 to 254 of c(m)·x(n-255+m). The newest sample therefore meets the padded zero tap. Samples from before the last reset count as zero.
- R2: The results of sample n become visible exactly N clock edges after the edge that accepts its strobe. Until then they keep their previous values.
- R3: `corr_vld_o` stays low for the first (N-1)·(256/N) samples after reset, which is 192 samples for N=4. It rises with the following sample and then stays high until the next reset.
- R4: `match_o` is 1 exactly when `corr_vld_o` is 1 and the magnitude of `corr_o` is greater than or equal to the unsigned `threshold_i`. The threshold is sampled in the last phase.
- R5: Full-scale samples aligned with the code (peak magnitude about 522,000) produce the exact sum, with no wrap.
- R6: Strobe spacing may be longer than N cycles and the results are unchanged. `sample_i` is ignored while the strobe is low, and the outputs hold during idle cycles.
- R7: A synchronous reset clears `corr_o`, `match_o` and `corr_vld_o` to 0. It also clears all stored samples and delayed partial sums and restarts the fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, at least N times the sample rate |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_vld_i | input | 1 | One-cycle strobe for a new sample, spaced at least N cycles apart |
| sample_i | input | SAMPLE_W | Signed sample |
| pn_code_i | input | CODE_LEN | Code bits, 0 means +1 and 1 means -1 |
| threshold_i | input | OUT_W | Unsigned magnitude threshold |
| corr_o | output | OUT_W | Signed correlation result |
| corr_vld_o | output | 1 | Result valid; set once the delay lines have filled |
| match_o | output | 1 | Acquisition flag |

## Verification
Several properties are checked on every cycle:
- The result stays stable outside the final phase.
- The valid flag never falls once it has risen.
- The match flag agrees with the registered magnitude and the sampled threshold.
- Strobes honour the minimum N-cycle spacing.
- The outputs are cleared right after a reset.

Only the bench's scenarios can show that the segment partial sums are realigned to the correct windows and that the valid flag rises on exactly the 193rd sample. They also cover the aligned full-scale peaks without wrap, the threshold equality edge, and the clearing of the delay contents by a reset.

// File: rtl/pnmf_pkg.sv
package pnmf_pkg;
   // taps per segment: the code is padded with zero taps up to NUM_SEG * seg
   function automatic int seg_len(input int code_len, input int num_seg);
      return (code_len + num_seg - 1) / num_seg;
   endfunction

   // bits needed for an index in 0 .. n-1 (at least one)
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pnmf_sequencer.sv
module pnmf_sequencer
   import pnmf_pkg::*;
#(
   parameter int NUM_SEG  = 2,
   parameter int FILL_LEN = 128,
   localparam int PH_W    = idx_w(NUM_SEG),
   localparam int FILL_W  = $clog2(FILL_LEN + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            sample_vld,
   output logic            busy,
   output logic [PH_W-1:0] phase,
   output logic            primed
);
   localparam logic [PH_W-1:0] LAST = PH_W'(NUM_SEG - 1);

   logic [FILL_W-1:0] fill_q;

   // a strobe starts a run of NUM_SEG phases; idle afterwards
   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         phase <= '0;
      end else if (sample_vld) begin
         busy  <= 1'b1;
         phase <= '0;
      end else if (busy) begin
         if (phase == LAST) busy  <= 1'b0;
         else               phase <= phase + 1'b1;
      end
   end

   // counts pushes into the longest delay line; primed once its head is real
   always_ff @(posedge clk) begin
      if (rst) begin
         fill_q <= '0;
         primed <= 1'b0;
      end else if (busy && phase == '0) begin
         if (fill_q == FILL_W'(FILL_LEN)) primed <= 1'b1;
         else                             fill_q <= fill_q + 1'b1;
      end
   end
endmodule

// File: rtl/pnmf_tap_bank.sv
module pnmf_tap_bank #(
   parameter int SAMPLE_W = 12,
   parameter int SEG_LEN  = 128,
   parameter int PSUM_W   = 20
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     shift_en,
   input  logic signed [SAMPLE_W-1:0] sample_in,
   input  logic [SEG_LEN-1:0]       tap_neg,
   input  logic [SEG_LEN-1:0]       tap_en,
   output logic signed [PSUM_W-1:0] psum
);
   // window[SEG_LEN-1] is the newest sample
   logic signed [SAMPLE_W-1:0] window [SEG_LEN];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < SEG_LEN; k++) window[k] <= '0;
      end else if (shift_en) begin
         for (int k = 0; k < SEG_LEN - 1; k++) window[k] <= window[k + 1];
         window[SEG_LEN-1] <= sample_in;
      end
   end

   // +/-1 taps: each product is a conditional negate, then one sum
   always_comb begin
      psum = '0;
      for (int k = 0; k < SEG_LEN; k++) begin
         if (tap_en[k]) begin
            if (tap_neg[k]) psum = psum - PSUM_W'(window[k]);
            else            psum = psum + PSUM_W'(window[k]);
         end
      end
   end
endmodule

// File: rtl/pnmf_delay_line.sv
module pnmf_delay_line
   import pnmf_pkg::*;
#(
   parameter int DEPTH  = 128,
   parameter int WIDTH  = 20,
   localparam int PTR_W = idx_w(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] head_q
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] ptr;

   // read-before-write at one pointer: exactly DEPTH pushes of delay
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         ptr    <= '0;
         head_q <= '0;
      end else if (push) begin
         head_q   <= mem[ptr];
         mem[ptr] <= din;
         ptr      <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      end
   end
endmodule

// File: rtl/pn_tdm_correlator.sv
module pn_tdm_correlator
   import pnmf_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter int CODE_LEN  = 255,
   parameter int NUM_SEG   = 2,
   localparam int SEG_LEN  = seg_len(CODE_LEN, NUM_SEG),
   localparam int TOT_TAPS = SEG_LEN * NUM_SEG,
   localparam int PSUM_W   = SAMPLE_W + $clog2(SEG_LEN) + 1,
   localparam int OUT_W    = SAMPLE_W + $clog2(CODE_LEN) + 1,
   localparam int PH_W     = idx_w(NUM_SEG),
   localparam int FILL_LEN = (NUM_SEG - 1) * SEG_LEN
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic                       sample_vld_i,
   input  logic signed [SAMPLE_W-1:0] sample_i,
   input  logic [CODE_LEN-1:0]        pn_code_i,
   input  logic [OUT_W-1:0]           threshold_i,
   output logic signed [OUT_W-1:0]    corr_o,
   output logic                       corr_vld_o,
   output logic                       match_o
);
   localparam logic [PH_W-1:0] LAST = PH_W'(NUM_SEG - 1);

   generate
      if (!(NUM_SEG == 2 || NUM_SEG == 4))
         $error("pn_tdm_correlator: NUM_SEG must be 2 or 4");
      if (SAMPLE_W < 2)
         $error("pn_tdm_correlator: SAMPLE_W too small");
      if (TOT_TAPS < CODE_LEN)
         $error("pn_tdm_correlator: segments do not cover the code");
   endgenerate

   logic            busy;
   logic [PH_W-1:0] phase;
   logic            primed;

   pnmf_sequencer #(.NUM_SEG(NUM_SEG), .FILL_LEN(FILL_LEN)) u_seq (
      .clk(clk_i), .rst(rst_i), .sample_vld(sample_vld_i),
      .busy(busy), .phase(phase), .primed(primed)
   );

   // padded code and tap-enable vectors; the pad taps are zero
   logic [TOT_TAPS-1:0] code_pad, en_pad;
   logic [SEG_LEN-1:0]  seg_neg, seg_en;
   assign code_pad = TOT_TAPS'(pn_code_i);
   assign en_pad   = TOT_TAPS'({CODE_LEN{1'b1}});
   assign seg_neg  = code_pad[int'(phase) * SEG_LEN +: SEG_LEN];
   assign seg_en   = en_pad[int'(phase) * SEG_LEN +: SEG_LEN];

   logic signed [PSUM_W-1:0] psum;

   pnmf_tap_bank #(.SAMPLE_W(SAMPLE_W), .SEG_LEN(SEG_LEN), .PSUM_W(PSUM_W)) u_taps (
      .clk(clk_i), .rst(rst_i), .shift_en(sample_vld_i), .sample_in(sample_i),
      .tap_neg(seg_neg), .tap_en(seg_en), .psum(psum)
   );

   // segment s waits (NUM_SEG-1-s) windows of SEG_LEN samples
   logic [PSUM_W-1:0] held [NUM_SEG-1];

   for (genvar s = 0; s < NUM_SEG - 1; s++) begin : g_seg
      pnmf_delay_line #(.DEPTH((NUM_SEG - 1 - s) * SEG_LEN), .WIDTH(PSUM_W)) u_dly (
         .clk(clk_i), .rst(rst_i),
         .push(busy && phase == PH_W'(s)),
         .din(psum), .head_q(held[s])
      );
   end

   logic signed [OUT_W-1:0] total;
   logic        [OUT_W-1:0] magnitude;

   always_comb begin
      total = OUT_W'(psum);
      for (int s = 0; s < NUM_SEG - 1; s++)
         total = total + OUT_W'(signed'(held[s]));
      magnitude = total[OUT_W-1] ? OUT_W'(-total) : OUT_W'(total);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         corr_o     <= '0;
         corr_vld_o <= 1'b0;
         match_o    <= 1'b0;
      end else if (busy && phase == LAST) begin
         corr_o     <= total;
         corr_vld_o <= primed;
         match_o    <= primed && (magnitude >= threshold_i);
      end
   end
endmodule

// File: rtl/pnmf_checker.sv
module pnmf_checker #(
   parameter int PH_W  = 1,
   parameter int LAST  = 1,
   parameter int OUT_W = 21
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    sample_vld,
   input logic                    busy,
   input logic [PH_W-1:0]         phase,
   input logic [OUT_W-1:0]        threshold,
   input logic signed [OUT_W-1:0] corr,
   input logic                    match,
   input logic                    out_vld
);
   function automatic logic [OUT_W-1:0] mag(input logic signed [OUT_W-1:0] v);
      return v[OUT_W-1] ? OUT_W'(-v) : OUT_W'(v);
   endfunction

   logic upd;
   assign upd = busy && (phase == PH_W'(LAST));

   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;

   // R2
   corr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(corr));

   // R3
   vld_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld |=> out_vld);

   // R4
   match_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
      match |-> out_vld);

   // R4
   match_level_chk: assert property (@(posedge clk) disable iff (rst)
      $past(upd) |-> (match == (out_vld && (mag(corr) >= $past(threshold)))));

   // R6
   strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      sample_vld |-> (!busy || phase == PH_W'(LAST)));

   // R7
   always @(posedge clk) begin
      if (rst_q) begin
         reset_clear_chk: assert (corr == '0 && !out_vld && !match);
      end
   end
endmodule

bind pn_tdm_correlator pnmf_checker #(.PH_W(PH_W), .LAST(NUM_SEG - 1), .OUT_W(OUT_W)) u_chk (
   .clk(clk_i), .rst(rst_i), .sample_vld(sample_vld_i), .busy(busy), .phase(phase),
   .threshold(threshold_i), .corr(corr_o), .match(match_o), .out_vld(corr_vld_o)
);

// File: tb/test_pn_tdm_correlator.sv
module test_pn_tdm_correlator;
   localparam int NSEG = 4;
   localparam int CLEN = 255;
   localparam int SW   = 12;
   localparam int OW   = 21;
   localparam int FILL = 192;   // (NSEG-1) * 64
   localparam int ROWS = 7;
   // stimulus kinds: 0 random, 1 code x500, 2 neg full scale, 3 pos full scale,
   // 4 inverted code x700, 5 zeros
   localparam int KIND [ROWS] = '{0, 1, 2, 3, 5, 0, 4};
   localparam int LEN  [ROWS] = '{200, 300, 300, 300, 260, 40, 255};
   localparam int GAP  [ROWS] = '{0, 0, 0, 0, 0, 4, 0};
   localparam int THR  [ROWS] = '{20000, 100000, 500000, 500000, 0, 30000, 60000};

   logic clk = 1'b0, rst = 1'b1, vld = 1'b0;
   logic signed [SW-1:0] din = '0;
   logic [OW-1:0] thr = '0;
   logic [CLEN-1:0] code = '0;
   logic signed [OW-1:0] corr;
   logic ovld, match;

   always #2.5 clk = ~clk;

   pn_tdm_correlator #(.SAMPLE_W(SW), .CODE_LEN(CLEN), .NUM_SEG(NSEG)) i_pn_tdm_correlator (
      .clk_i(clk), .rst_i(rst), .sample_vld_i(vld), .sample_i(din), .pn_code_i(code),
      .threshold_i(thr), .corr_o(corr), .corr_vld_o(ovld), .match_o(match)
   );

   int n_chk = 0, n_bad = 0;
   int hist [256];
   int cnt = 0;
   bit pend = 0, p_v, p_m;
   int p_y;
   string p_tag;
   int unsigned rng = 32'h1234_5678;
   string tags [ROWS] = '{"R1", "R1", "R5", "R5", "R4", "R6", "R4"};

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int cval(input int m);
      return code[m] ? -1 : 1;
   endfunction

   // result for the next sample: the newest sample meets the zero tap
   function automatic int model_y();
      int y = 0;
      for (int m = 0; m < CLEN; m++) y += cval(m) * hist[m + 1];
      return y;
   endfunction

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic int gen(input int kind, input int j);
      int m = j % CLEN;
      case (kind)
         0: begin
            rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
            return int'(rng % 4096) - 2048;
         end
         1: return code[m] ? -500 : 500;
         2: return code[m] ? 2047 : -2048;
         3: return code[m] ? -2048 : 2047;
         4: return code[m] ? 700 : -700;
         default: return 0;
      endcase
   endfunction

   task automatic check_pending();
      if (pend) begin
         check(int'(corr) == p_y, p_tag, "corr", corr, p_y);
         check(ovld == p_v, "R3", "corr_vld", ovld, p_v);
         check(match == p_m, "R4", "match", match, p_m);
         pend = 0;
      end
   endtask

   task automatic drive(input int x, input int t, input int gap, input string tag);
      int y = model_y();
      for (int k = 0; k < 255; k++) hist[k] = hist[k + 1];
      hist[255] = x;
      cnt++;
      @(negedge clk); din = SW'(x); vld = 1'b1;
      @(negedge clk); vld = 1'b0;
      check_pending();
      thr  = OW'(t);
      pend = 1; p_y = y; p_v = (cnt > FILL); p_m = p_v && (iabs(y) >= t); p_tag = tag;
      repeat (NSEG - 2 + gap) @(negedge clk);
   endtask

   task automatic flush();
      repeat (NSEG + 1) @(negedge clk);
      check_pending();
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; vld = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 256; k++) hist[k] = 0;
      cnt = 0; pend = 0;
      check(corr == '0, "R7", "corr after reset", corr, 0);
      check(ovld == 1'b0, "R7", "corr_vld after reset", ovld, 0);
      check(match == 1'b0, "R7", "match after reset", match, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] s = 8'h01;
      int y0, yb;
      for (int i = 0; i < CLEN; i++) begin
         code[i] = s[0];
         s = {s[0] ^ s[2] ^ s[3] ^ s[4], s[7:1]};
      end
      do_reset();

      // table walk: back-to-back strobes, plus one gapped row
      for (int r = 0; r < ROWS; r++)
         for (int j = 0; j < LEN[r]; j++)
            drive(gen(KIND[r], j), THR[r], GAP[r], tags[r]);
      flush();

      // R4 threshold equality edge, then one above
      for (int j = 0; j < 20; j++) drive(gen(0, j), 1000, 0, "R1");
      yb = model_y();
      drive(gen(0, 0), iabs(yb), 0, "R4");
      yb = model_y();
      drive(gen(0, 0), iabs(yb) + 1, 0, "R4");
      flush();
      check(match == 1'b0, "R4", "match one above magnitude", match, 0);

      // R2 result appears exactly NSEG edges after the accepting edge
      y0 = int'(corr);
      yb = model_y();
      for (int k = 0; k < 255; k++) hist[k] = hist[k + 1];
      hist[255] = 77; cnt++;
      @(negedge clk); din = SW'(77); vld = 1'b1;
      @(negedge clk); vld = 1'b0;
      repeat (NSEG - 1) @(negedge clk);
      check(int'(corr) == y0, "R2", "corr before last phase", corr, y0);
      @(negedge clk);
      check(int'(corr) == yb, "R2", "corr after last phase", corr, yb);

      // R6 sample input ignored without strobe; outputs hold
      y0 = int'(corr);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk); din = SW'(gen(0, k));
      end
      check(int'(corr) == y0, "R6", "corr held while idle", corr, y0);
      for (int j = 0; j < 10; j++) drive(gen(0, j), 1000, 0, "R6");
      flush();

      // R7 mid-run reset clears stored state and the fill count
      do_reset();
      for (int j = 0; j < FILL; j++) drive(0, 0, 0, "R7");
      flush();
      check(ovld == 1'b0, "R3", "corr_vld after 192 samples", ovld, 0);
      drive(gen(0, 1), 0, 0, "R7");
      flush();
      check(ovld == 1'b1, "R3", "corr_vld after 193 samples", ovld, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule